// File: doc/BRIEF.md
# Train Command Line Serializer

This block drives a single serial fast-command line that runs at one bit per cycle of a fast clock, about 100 MHz and phase-locked to a 5 MHz bunch clock. Every command starts with a fixed 4-bit code. The start-of-train command also carries a 48-bit payload. That payload holds an internally kept train number, a bunch-pattern identifier and an 8-bit checksum. The other commands are the end-of-train command, a front-end microcontroller reset command and a spare command. Each of these is the 4-bit code alone.

The timing system marks each train one fixed period ahead of its arrival. That period is `PERIOD_STEPS` strobes of the 5 MHz phase strobe. After the mark, the block counts strobes down. It launches the start frame when the remaining distance to the train reaches the programmed lead, which is given in whole strobe periods. A start frame always begins on the first fast cycle after a strobe. Its phase to the bunch clock is therefore fixed. The train number starts at zero after reset. It advances by one only after a frame has been fully sent, so a number is never repeated.

Short commands are requested with one-cycle pulses. If the line is busy, the request is held and sent as soon as the line frees up, with no gap after the current command.

Top module: `trainCmdSer`

## Requirements
- R1: After reset the line is low and the first start frame carries train number 0.
- R2: Command codes are sent most-significant bit first, one bit per cycle: start 1100, end-of-train 1010, microcontroller reset 1001, spare 1111. The line is low whenever no command is being sent.
- R3: A start frame is 52 consecutive bits, all MSB first, in this order: code 1100, the 32-bit train number, the 8-bit bunch pattern sampled on the launch strobe cycle, then the 8-bit checksum.
- R4: The checksum is the sum, modulo 256, of the four bytes of the train number and the bunch-pattern byte.
- R5: The train number goes up by exactly one for each start frame sent, and it never changes in any other way.
- R6: Let k = PERIOD_STEPS − lead. The first bit of a start frame appears on the cycle after the k-th strobe that follows the train mark. A strobe in the same cycle as the mark is not counted.
- R7: If the lead is greater than or equal to PERIOD_STEPS, the start frame follows the first strobe after the mark.
- R8: A new train mark that arrives while a countdown is running restarts the countdown. Only one frame is sent, timed from the latest mark.
- R9: On an idle line, a command request puts the first code bit on the line in the cycle after the request. No two commands are ever loaded in the same cycle.
- R10: Requests that arrive during a start frame are held. They are sent back to back right after the frame's last bit, in this order: end-of-train, then reset, then spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, phase-locked to the bunch clock |
| rstN | input | 1 | Active-low synchronous reset |
| bunchStrobe | input | 1 | One-cycle pulse per 5 MHz bunch-clock period |
| trainMark | input | 1 | One-cycle pulse marking a train PERIOD_STEPS strobes ahead |
| leadSteps | input | CNT_W | Start lead before train arrival, in strobe periods |
| bunchPattern | input | 8 | Bunch-pattern identifier placed in the start frame |
| stopReq | input | 1 | Request the end-of-train command |
| ucResetReq | input | 1 | Request the microcontroller reset command |
| spareReq | input | 1 | Request the spare command |
| cmdLine | output | 1 | Serial command line |

## Verification
If the countdown or the strobe alignment is wrong, the start frame's first bit moves. The bench checks the exact cycle against a count of strobes since the mark, so the error shows within the same train. A wrong train-number register or checksum corrupts bits 5 to 52 of the very next frame. A lost or misordered pending request shows as a missing, extra or reordered code in the 12 cycles after that frame. Because every command begins with a one, a stray high bit on the idle line is decoded as a command that nobody expected.

// File: rtl/tcsPkg.sv
package tcsPkg;
  localparam int CODE_W  = 4;
  localparam int TRAIN_W = 32;
  localparam int PAT_W   = 8;
  localparam int SUM_W   = 8;
  localparam int FRAME_W = CODE_W + TRAIN_W + PAT_W + SUM_W;

  localparam logic [CODE_W-1:0] CODE_START = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_STOP  = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_UCRST = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_SPARE = 4'b1111;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadFrame;
    logic              loadCode;
    logic [CODE_W-1:0] code;
    logic              bumpTrain;
  } tcsStrobe_t;

  function automatic logic [SUM_W-1:0] frameSum(input logic [TRAIN_W-1:0] num,
                                                input logic [PAT_W-1:0] pat);
    logic [SUM_W-1:0] acc;
    acc = pat;
    for (int i = 0; i < TRAIN_W / SUM_W; i++) acc = acc + num[i*SUM_W +: SUM_W];
    return acc;
  endfunction
endpackage

// File: rtl/tcsControl.sv
module tcsControl import tcsPkg::*; #(
  parameter int PERIOD_STEPS = 16,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bunchStrobe,
  input  logic             trainMark,
  input  logic [CNT_W-1:0] leadSteps,
  input  logic             stopReq,
  input  logic             ucResetReq,
  input  logic             spareReq,
  output tcsStrobe_t       strb
);
  localparam int REM_W = $clog2(FRAME_W);
  localparam logic [REM_W-1:0] FRAME_LAST = REM_W'(FRAME_W - 1);
  localparam logic [REM_W-1:0] CODE_LAST  = REM_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] PERIOD_V   = CNT_W'(PERIOD_STEPS);

  logic [REM_W-1:0]  remain;
  logic              frameActive, armed;
  logic [CNT_W-1:0]  stepsLeft, stepsDec;
  logic              pendStop, pendUc, pendSpare;
  logic              wantStop, wantUc, wantSpare;
  logic              lineFree, launch, issue;
  logic [CODE_W-1:0] pickCode;

  always_comb begin
    lineFree  = (remain == '0);
    stepsDec  = (stepsLeft == '0) ? '0 : stepsLeft - CNT_W'(1);
    launch    = bunchStrobe && armed && !trainMark && (stepsDec <= leadSteps)
                && lineFree && !frameActive;
    wantStop  = pendStop  | stopReq;
    wantUc    = pendUc    | ucResetReq;
    wantSpare = pendSpare | spareReq;
    issue     = lineFree && !launch && (wantStop || wantUc || wantSpare);
    if (wantStop)    pickCode = CODE_STOP;
    else if (wantUc) pickCode = CODE_UCRST;
    else             pickCode = CODE_SPARE;
    strb.loadFrame = launch;
    strb.loadCode  = issue;
    strb.code      = pickCode;
    strb.bumpTrain = frameActive && lineFree;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain      <= '0;
      frameActive <= 1'b0;
      armed       <= 1'b0;
      stepsLeft   <= '0;
      pendStop    <= 1'b0;
      pendUc      <= 1'b0;
      pendSpare   <= 1'b0;
    end else begin
      if (launch)        remain <= FRAME_LAST;
      else if (issue)    remain <= CODE_LAST;
      else if (!lineFree) remain <= remain - REM_W'(1);

      if (launch)                       frameActive <= 1'b1;
      else if (frameActive && lineFree) frameActive <= 1'b0;

      if (trainMark) begin
        armed     <= 1'b1;
        stepsLeft <= PERIOD_V;
      end else if (launch) begin
        armed <= 1'b0;
      end else if (bunchStrobe && armed) begin
        stepsLeft <= stepsDec;
      end

      pendStop  <= wantStop  && !(issue && wantStop);
      pendUc    <= wantUc    && !(issue && !wantStop);
      pendSpare <= wantSpare && !(issue && !wantStop && !wantUc);
    end
  end
endmodule

// File: rtl/tcsDatapath.sv
module tcsDatapath import tcsPkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  tcsStrobe_t         strb,
  input  logic [PAT_W-1:0]   bunchPattern,
  output logic               cmdLine,
  output logic [TRAIN_W-1:0] trainNum
);
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frameWord;
  logic               lineQ;

  always_comb frameWord = {CODE_START, trainNum, bunchPattern, frameSum(trainNum, bunchPattern)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg    <= '0;
      lineQ    <= 1'b0;
      trainNum <= '0;
    end else begin
      if (strb.loadFrame) begin
        lineQ <= frameWord[FRAME_W-1];
        shreg <= {frameWord[FRAME_W-2:0], 1'b0};
      end else if (strb.loadCode) begin
        lineQ <= strb.code[CODE_W-1];
        shreg <= {strb.code[CODE_W-2:0], {(FRAME_W-CODE_W+1){1'b0}}};
      end else begin
        lineQ <= shreg[FRAME_W-1];
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
      if (strb.bumpTrain) trainNum <= trainNum + TRAIN_W'(1);
    end
  end

  assign cmdLine = lineQ;
endmodule

// File: rtl/trainCmdSer.sv
module trainCmdSer import tcsPkg::*; #(
  parameter  int PERIOD_STEPS = 16,
  localparam int CNT_W        = $clog2(PERIOD_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bunchStrobe,
  input  logic             trainMark,
  input  logic [CNT_W-1:0] leadSteps,
  input  logic [PAT_W-1:0] bunchPattern,
  input  logic             stopReq,
  input  logic             ucResetReq,
  input  logic             spareReq,
  output logic             cmdLine
);
  tcsStrobe_t         strb;
  logic [TRAIN_W-1:0] trainNum;

  tcsControl #(.PERIOD_STEPS(PERIOD_STEPS), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .bunchStrobe(bunchStrobe), .trainMark(trainMark),
    .leadSteps(leadSteps), .stopReq(stopReq), .ucResetReq(ucResetReq),
    .spareReq(spareReq), .strb(strb)
  );

  tcsDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bunchPattern(bunchPattern),
    .cmdLine(cmdLine), .trainNum(trainNum)
  );
endmodule

// File: rtl/tcsChecker.sv
module tcsChecker import tcsPkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               bunchStrobe,
  input logic               cmdLine,
  input tcsStrobe_t         strb,
  input logic [TRAIN_W-1:0] trainNum
);
  // R2: every code starts with a one on the line
  p_code_lead_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCode |=> cmdLine);
  // R6: a start frame is only loaded on a strobe cycle
  p_frame_on_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |-> bunchStrobe);
  // R9: never two loads at once
  p_one_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadFrame && strb.loadCode));
  // R3: a frame keeps the line for more than one cycle
  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> !strb.loadFrame && !strb.loadCode);
  // R5: the train number only steps up by one
  p_train_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trainNum != $past(trainNum)) |-> (trainNum == $past(trainNum) + TRAIN_W'(1)));
endmodule

bind trainCmdSer tcsChecker u_chk (
  .clk(clk), .rstN(rstN), .bunchStrobe(bunchStrobe), .cmdLine(cmdLine),
  .strb(strb), .trainNum(trainNum)
);

// File: tb/trainCmdSer_bench.sv
module trainCmdSer_bench;
  localparam int PERIOD = 16;
  localparam int CNT_W  = $clog2(PERIOD + 1);
  localparam int SPAN   = 20;

  typedef struct {
    logic [3:0]  code;
    logic [47:0] payload;
    int          atCyc;
    string       tag;
  } expItem_t;

  logic clk = 0, rstN = 0, bunchStrobe = 0, trainMark = 0;
  logic stopReq = 0, ucResetReq = 0, spareReq = 0;
  logic [CNT_W-1:0] leadSteps = '0;
  logic [7:0] bunchPattern = '0;
  logic cmdLine;

  int cyc = 0, checks = 0, errors = 0;
  logic [31:0] expTrain = 0;
  expItem_t expQ[$];

  trainCmdSer #(.PERIOD_STEPS(PERIOD)) u_trainCmdSer (
    .clk(clk), .rstN(rstN), .bunchStrobe(bunchStrobe), .trainMark(trainMark),
    .leadSteps(leadSteps), .bunchPattern(bunchPattern), .stopReq(stopReq),
    .ucResetReq(ucResetReq), .spareReq(spareReq), .cmdLine(cmdLine)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) bunchStrobe <= (cyc % SPAN == 0);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sum8(input logic [31:0] t, input logic [7:0] p);
    return t[31:24] + t[23:16] + t[15:8] + t[7:0] + p;
  endfunction

  // Driver: mark a train and push the expected frame
  task automatic trainRun(input int lead, input logic [7:0] pat, input string tag,
                          output int firstBit);
    expItem_t e;
    int n;
    @(negedge clk);
    if (cyc % SPAN == 0) @(negedge clk);
    bunchPattern = pat;
    leadSteps    = CNT_W'(lead);
    trainMark    = 1;
    n = PERIOD - lead;
    if (n < 1) n = 1;
    firstBit = (cyc / SPAN + 1) * SPAN + (n - 1) * SPAN + 1;
    e.code = 4'b1100;
    e.payload = {expTrain, pat, sum8(expTrain, pat)};
    e.atCyc = firstBit;
    e.tag = tag;
    expQ.push_back(e);
    expTrain++;
    @(negedge clk) trainMark = 0;
  endtask

  task automatic pushCode(input logic [3:0] code, input int at, input string tag);
    expItem_t e;
    e.code = code; e.payload = '0; e.atCyc = at; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Monitor: decode commands off the line and compare
  initial begin
    int startC;
    logic [3:0] cd;
    logic [47:0] pl;
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && cmdLine === 1'b1) begin
        startC = cyc;
        cd = 4'b1000;
        pl = '0;
        for (int i = 2; i >= 0; i--) begin @(negedge clk); cd[i] = cmdLine; end
        if (cd == 4'b1100)
          for (int i = 47; i >= 0; i--) begin @(negedge clk); pl[i] = cmdLine; end
        if (expQ.size() == 0) begin
          check(0, "R2", "unexpected command", {60'd0, cd}, 64'd0);
        end else begin
          e = expQ.pop_front();
          check(cd == e.code, e.tag, "code", {60'd0, cd}, {60'd0, e.code});
          check(startC == e.atCyc, e.tag, "first bit cycle", 64'(startC), 64'(e.atCyc));
          if (e.code == 4'b1100)
            check(pl == e.payload, e.tag, "payload", {16'd0, pl}, {16'd0, e.payload});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fb, r;
    repeat (5) @(negedge clk);
    check(cmdLine == 1'b0, "R1", "line low in reset", {63'd0, cmdLine}, 64'd0);
    rstN = 1;
    repeat (10) @(negedge clk);
    check(cmdLine == 1'b0, "R1", "line low after reset", {63'd0, cmdLine}, 64'd0);

    // R1 R3 R4 R6: first train, lead 3
    trainRun(3, 8'h5A, "R6", fb);
    drain();
    // R4 checksum wraps (1 + 0xFF), lead 0
    trainRun(0, 8'hFF, "R4", fb);
    drain();
    // R9: idle end-of-train request
    @(negedge clk); stopReq = 1; r = cyc; pushCode(4'b1010, r + 1, "R9");
    @(negedge clk); stopReq = 0;
    drain();
    // R7: lead equal to period, then R10 requests during the frame
    trainRun(PERIOD, 8'h00, "R7", fb);
    while (cyc < fb + 5) @(negedge clk);
    spareReq = 1; ucResetReq = 1; stopReq = 1;
    pushCode(4'b1010, fb + 52, "R10");
    pushCode(4'b1001, fb + 56, "R10");
    pushCode(4'b1111, fb + 60, "R10");
    @(negedge clk); spareReq = 0; ucResetReq = 0; stopReq = 0;
    drain();
    // R8: mark, wait five strobes, mark again
    @(negedge clk);
    if (cyc % SPAN == 0) @(negedge clk);
    leadSteps = CNT_W'(10); trainMark = 1;
    @(negedge clk) trainMark = 0;
    repeat (5 * SPAN) @(negedge clk);
    trainRun(10, 8'hC3, "R8", fb);
    drain();
    // R9 R2: idle reset and spare requests
    @(negedge clk); ucResetReq = 1; r = cyc; pushCode(4'b1001, r + 1, "R9");
    @(negedge clk); ucResetReq = 0;
    drain();
    @(negedge clk); spareReq = 1; r = cyc; pushCode(4'b1111, r + 1, "R2");
    @(negedge clk); spareReq = 0;
    drain();
    // R5: one more frame shows the number advanced by exactly one each time
    trainRun(2, 8'h81, "R5", fb);
    drain();
    repeat (200) @(negedge clk);
    check(expQ.size() == 0, "R2", "outstanding commands", 64'(expQ.size()), 64'd0);
    check(cmdLine == 1'b0, "R2", "idle line low", {63'd0, cmdLine}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule